// File: doc/BRIEF.md
# Unprivileged Halfword Store Decode and Address Unit

This block recognises one store instruction in three encodings and turns it into a single memory write request and, where the encoding asks for it, an update of the base register. The instruction word, an encoding-set select, an issue strobe, a condition-pass flag and the current privilege level come in together in one cycle. The block presents the three register indices it needs on a read port and takes the values back in the same cycle. One cycle later it drives the request and the writeback.

Two encoding families are handled. The compact encoding adds an 8-bit immediate to the base and leaves the base register unchanged. The two fixed-length encodings use post-indexed addressing with an immediate or a register offset. The fixed-length forms store to the unmodified base and then write base plus or minus the offset back into the base register. Every request carries a 2-byte size and a flag that tells the memory system to check permissions as for user level, whatever the current privilege.

The block also flags illegal register combinations and the hypervisor privilege level. Condition evaluation, the register file, the memory system and exception handling are outside the block.

Top module: `sthu_store_unit`

## Requirements
- R1: Compact form (`isa_sel`=1, `instr[31:20]`=0xF82, `instr[11:8]`=0xE): the address is Rn + zero-extended `instr[7:0]`, where Rn=`instr[19:16]` and Rt=`instr[15:12]`. There is no writeback.
- R2: Fixed-length forms (`isa_sel`=0): the request address is the unmodified Rn value. The writeback goes to index Rn and carries the offset address.
- R3: Fixed immediate form: `instr[31:28]`≠0xF, `instr[27:24]`=0, `instr[22:20]`=3'b110 and `instr[7:4]`=0xB. The offset is {`instr[11:8]`,`instr[3:0]`} zero-extended. When `instr[23]`=1 the offset is added to the base; when it is 0 the offset is subtracted.
- R4: Fixed register form: as R3, except `instr[22:20]`=3'b010 and `instr[11:8]`=0. The offset is the full 32-bit value of Rm=`instr[3:0]`, added or subtracted according to `instr[23]`.
- R5: Each request carries `rt_val[15:0]` as data, `mem_size`=2'b01 (two bytes) and `mem_user`=1.
- R6: Compact form with Rn=15 raises `undef_o`. No request and no writeback are issued, and `unpred_o` stays low.
- R7: `unpred_o` is raised in these cases: compact Rt=15; fixed Rt=15, Rn=15 or Rn=Rt; register form Rm=15. The store is still issued but the writeback is suppressed.
- R8: An instruction that matches and executes while `el`=2 (hypervisor) raises `unpred_o` and suppresses the writeback.
- R9: If `cond_pass` is low, the outputs show no request, no writeback and no flag.
- R10: All outputs are registered. They appear one cycle after `in_valid`, last one cycle, and are zero otherwise. Address arithmetic wraps modulo 2^32.
- R11: A word that matches none of the three forms produces no output. This includes a register form with nonzero `instr[11:8]`.
- R12: During reset and directly after it, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction issue strobe |
| isa_sel | input | 1 | 0 selects the fixed-length set, 1 the compact set |
| instr | input | 32 | Instruction word (compact: first halfword in [31:16]) |
| cond_pass | input | 1 | Condition check result |
| el | input | 2 | Current privilege level, 2 = hypervisor |
| rd_n_idx | output | 4 | Base register index for the read port |
| rd_m_idx | output | 4 | Index register index for the read port |
| rd_t_idx | output | 4 | Data register index for the read port |
| rn_val | input | 32 | Base register value |
| rm_val | input | 32 | Index register value |
| rt_val | input | 32 | Data register value |
| mem_req | output | 1 | Memory write request strobe |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 16 | Halfword to store |
| mem_size | output | 2 | Log2 of the access size in bytes |
| mem_user | output | 1 | Check the access with user-level permissions |
| wb_en | output | 1 | Base-register writeback strobe |
| wb_idx | output | 4 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| undef_o | output | 1 | Undefined instruction flag |
| unpred_o | output | 1 | Unpredictable instruction flag |

## Verification
The cases that are hardest to reach from the ports are the illegal ones: Rn equal to Rt, the index register at 15, and the overlap of hypervisor level with an undefined compact word. With uniformly random register fields these come up about once in sixteen draws. The stimulus therefore picks each register field as 15, as a copy of another field, or as a random value, with about equal weight. The privilege level is set to hypervisor in a fixed share of draws. Directed cases cover subtraction below zero, addition past 2^32, and a register-form word with the reserved bits set.

// File: rtl/sthu_pkg.sv
package sthu_pkg;
  localparam int INSN_W = 32;
  localparam int RIDX_W = 4;
  localparam logic [RIDX_W-1:0] REG_PC = 4'hF;
  localparam logic [1:0] EL_HYP    = 2'd2;
  localparam logic [1:0] SIZE_HALF = 2'b01;

  typedef enum logic {ISA_FIXED = 1'b0, ISA_COMPACT = 1'b1} isa_e;
  typedef enum logic [1:0] {
    FORM_NONE    = 2'd0,
    FORM_FIX_IMM = 2'd1,
    FORM_FIX_REG = 2'd2,
    FORM_CMP_IMM = 2'd3
  } form_e;

  typedef struct packed {
    form_e             form;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rm;
    logic [7:0]        imm8;
    logic              add;
    logic              postidx;
  } dec_t;
endpackage

// File: rtl/sthu_decode.sv
module sthu_decode
  import sthu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  input  logic              isa_sel,
  output dec_t              dec,
  output logic              enc_undef,
  output logic              enc_unpred
);
  logic hit_fimm, hit_freg, hit_cmp, fix_common;

  always_comb begin
    fix_common = (isa_sel == ISA_FIXED) && (instr[31:28] != 4'hF) &&
                 (instr[27:24] == 4'h0) && (instr[7:4] == 4'hB);
    hit_fimm   = fix_common && (instr[22:20] == 3'b110);
    hit_freg   = fix_common && (instr[22:20] == 3'b010) && (instr[11:8] == 4'h0);
    hit_cmp    = (isa_sel == ISA_COMPACT) && (instr[31:20] == 12'hF82) &&
                 (instr[11:8] == 4'hE);
  end

  always_comb begin
    dec.rn = instr[19:16];
    dec.rt = instr[15:12];
    dec.rm = instr[3:0];
    if (hit_cmp) begin
      dec.form    = FORM_CMP_IMM;
      dec.imm8    = instr[7:0];
      dec.add     = 1'b1;
      dec.postidx = 1'b0;
    end else begin
      dec.form    = hit_fimm ? FORM_FIX_IMM : (hit_freg ? FORM_FIX_REG : FORM_NONE);
      dec.imm8    = {instr[11:8], instr[3:0]};
      dec.add     = instr[23];
      dec.postidx = 1'b1;
    end
  end

  always_comb begin
    enc_undef  = 1'b0;
    enc_unpred = 1'b0;
    unique case (dec.form)
      FORM_CMP_IMM: begin
        enc_undef  = (dec.rn == REG_PC);
        enc_unpred = (dec.rt == REG_PC);
      end
      FORM_FIX_IMM, FORM_FIX_REG: begin
        enc_unpred = (dec.rt == REG_PC) || (dec.rn == REG_PC) || (dec.rn == dec.rt) ||
                     ((dec.form == FORM_FIX_REG) && (dec.rm == REG_PC));
      end
      default: ;
    endcase
  end

  always_comb begin
    a_one_form_r11: assert ($onehot0({hit_fimm, hit_freg, hit_cmp}));
  end
endmodule

// File: rtl/sthu_agu.sv
module sthu_agu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  input  logic            add,
  input  logic            postidx,
  output logic [XLEN-1:0] acc_addr,
  output logic [XLEN-1:0] next_base
);
  always_comb begin
    next_base = add ? (base + offset) : (base - offset);
    acc_addr  = postidx ? base : next_base;
  end
endmodule

// File: rtl/sthu_store_unit.sv
module sthu_store_unit
  import sthu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              isa_sel,
  input  logic [INSN_W-1:0] instr,
  input  logic              cond_pass,
  input  logic [1:0]        el,
  output logic [RIDX_W-1:0] rd_n_idx,
  output logic [RIDX_W-1:0] rd_m_idx,
  output logic [RIDX_W-1:0] rd_t_idx,
  input  logic [XLEN-1:0]   rn_val,
  input  logic [XLEN-1:0]   rm_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_size,
  output logic              mem_user,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              undef_o,
  output logic              unpred_o
);
  localparam int HALF_W = 16;

  dec_t            dec;
  logic            enc_undef, enc_unpred;
  logic [XLEN-1:0] offset, acc_addr, next_base;

  sthu_decode u_dec (
    .instr      (instr),
    .isa_sel    (isa_sel),
    .dec        (dec),
    .enc_undef  (enc_undef),
    .enc_unpred (enc_unpred)
  );

  assign rd_n_idx = dec.rn;
  assign rd_m_idx = dec.rm;
  assign rd_t_idx = dec.rt;

  always_comb begin
    if (dec.form == FORM_FIX_REG) offset = rm_val;
    else                          offset = {{(XLEN-8){1'b0}}, dec.imm8};
  end

  sthu_agu #(.XLEN(XLEN)) u_agu (
    .base      (rn_val),
    .offset    (offset),
    .add       (dec.add),
    .postidx   (dec.postidx),
    .acc_addr  (acc_addr),
    .next_base (next_base)
  );

  // next-state signals
  logic              fire, n_req, n_wb, n_undef, n_unpred;
  logic [XLEN-1:0]   n_addr, n_wbd;
  logic [HALF_W-1:0] n_wdata;
  logic [RIDX_W-1:0] n_widx;

  always_comb begin
    fire     = in_valid && cond_pass && (dec.form != FORM_NONE);
    n_undef  = fire && enc_undef;
    n_unpred = fire && !enc_undef && (enc_unpred || (el == EL_HYP));
    n_req    = fire && !enc_undef;
    n_wb     = n_req && !n_unpred && dec.postidx;
    n_addr   = n_req ? acc_addr : '0;
    n_wdata  = n_req ? rt_val[HALF_W-1:0] : '0;
    n_wbd    = n_wb ? next_base : '0;
    n_widx   = n_wb ? dec.rn : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_size  <= '0;
      mem_user  <= 1'b0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      undef_o   <= 1'b0;
      unpred_o  <= 1'b0;
    end else begin
      mem_req   <= n_req;
      mem_addr  <= n_addr;
      mem_wdata <= n_wdata;
      mem_size  <= n_req ? SIZE_HALF : 2'b00;
      mem_user  <= n_req;
      wb_en     <= n_wb;
      wb_idx    <= n_widx;
      wb_data   <= n_wbd;
      undef_o   <= n_undef;
      unpred_o  <= n_unpred;
    end
  end

  p_wb_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_req);
  p_req_attrs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_user && mem_size == SIZE_HALF));
  p_undef_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!mem_req && !wb_en && !unpred_o));
  p_unpred_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !wb_en);
  p_hyp_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_pass && el == EL_HYP) |=> !wb_en);
  p_cond_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && cond_pass) |=> (!mem_req && !wb_en && !undef_o && !unpred_o));
  p_compact_no_wb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_sel == ISA_COMPACT) |=> !wb_en);
endmodule

// File: tb/sthu_store_unit_tb.sv
`timescale 1ns/1ps
module sthu_store_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, isa_sel, cond_pass;
  logic [31:0] instr;
  logic [1:0]  el;
  logic [3:0]  rd_n_idx, rd_m_idx, rd_t_idx;
  logic [31:0] rn_val, rm_val, rt_val;
  logic        mem_req, mem_user, wb_en, undef_o, unpred_o;
  logic [31:0] mem_addr, wb_data;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_size;
  logic [3:0]  wb_idx;

  logic [31:0] rf [16];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [90:0] exp_v;
  string exp_tag;

  always #4 clk = ~clk;

  always_comb begin
    rn_val = rf[rd_n_idx];
    rm_val = rf[rd_m_idx];
    rt_val = rf[rd_t_idx];
  end

  sthu_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .isa_sel(isa_sel),
    .instr(instr), .cond_pass(cond_pass), .el(el),
    .rd_n_idx(rd_n_idx), .rd_m_idx(rd_m_idx), .rd_t_idx(rd_t_idx),
    .rn_val(rn_val), .rm_val(rm_val), .rt_val(rt_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_size(mem_size), .mem_user(mem_user), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .undef_o(undef_o), .unpred_o(unpred_o)
  );

  // reference model written from the requirements
  task automatic model(input logic v, input logic isa, input logic [31:0] w,
                       input logic cp, input logic [1:0] lvl);
    logic fimm, freg, fcmp, req, wb, un, up;
    logic [3:0] n, t, m;
    logic [31:0] off, base, nb, addr;
    n = w[19:16]; t = w[15:12]; m = w[3:0];
    fimm = !isa && w[31:28] != 4'hF && w[27:24] == 0 && w[22:20] == 3'b110 && w[7:4] == 4'hB;
    freg = !isa && w[31:28] != 4'hF && w[27:24] == 0 && w[22:20] == 3'b010 &&
           w[11:8] == 0 && w[7:4] == 4'hB;
    fcmp = isa && w[31:20] == 12'hF82 && w[11:8] == 4'hE;
    base = rf[n];
    un = 0; up = 0; req = 0; wb = 0; addr = 0; nb = 0;
    exp_tag = "R10";
    if (v && !(fimm || freg || fcmp)) exp_tag = "R11";
    if (v && !cp) exp_tag = "R9";
    if (v && cp && fcmp) begin
      exp_tag = "R1";
      un = (n == 4'hF);
      up = !un && ((t == 4'hF) || lvl == 2'd2);
      req = !un;
      addr = base + {24'd0, w[7:0]};
      if (un) exp_tag = "R6";
    end else if (v && cp && (fimm || freg)) begin
      exp_tag = fimm ? "R3" : "R4";
      off = fimm ? {24'd0, w[11:8], w[3:0]} : rf[m];
      nb  = w[23] ? base + off : base - off;
      up  = t == 4'hF || n == 4'hF || n == t || (freg && m == 4'hF) || lvl == 2'd2;
      req = 1; addr = base; wb = !up;
    end
    if (up) exp_tag = (lvl == 2'd2) ? "R8" : "R7";
    exp_v = {req, req ? addr : 32'd0, req ? rf[t][15:0] : 16'd0,
             req ? 2'b01 : 2'b00, req, wb, wb ? n : 4'd0, wb ? nb : 32'd0, un, up};
  endtask

  task automatic drive(input logic v, input logic isa, input logic [31:0] w,
                       input logic cp, input logic [1:0] lvl);
    in_valid = v; isa_sel = isa; instr = w; cond_pass = cp; el = lvl;
    model(v, isa, w, cp, lvl);
  endtask

  task automatic check(input string tag);
    logic [90:0] act;
    act = {mem_req, mem_addr, mem_wdata, mem_size, mem_user, wb_en, wb_idx,
           wb_data, undef_o, unpred_o};
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic step(input logic v, input logic isa, input logic [31:0] w,
                      input logic cp, input logic [1:0] lvl, input string tag);
    string tg;
    drive(v, isa, w, cp, lvl);
    tg = (tag == "") ? exp_tag : tag;
    @(negedge clk);
    check(tg);
  endtask

  function automatic logic [3:0] pick(input logic [3:0] other);
    int s = $urandom_range(0, 2);
    return (s == 0) ? 4'hF : (s == 1) ? other : 4'($urandom);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    rst_n = 0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R12");                         // outputs quiet in reset
    rst_n = 1;
    @(negedge clk);
    check("R12");

    // directed: R3 subtract wraps below zero, writeback to Rn
    rf[2] = 32'd0; rf[5] = 32'h0000ABCD;
    step(1, 0, {4'hE, 4'h0, 1'b0, 3'b110, 4'd2, 4'd5, 4'h0, 4'hB, 4'h1}, 1, 0, "R10");
    // directed: R1 compact add wraps past 2^32
    rf[3] = 32'hFFFF_FFF0;
    step(1, 1, {12'hF82, 4'd3, 4'd5, 4'hE, 8'hFF}, 1, 0, "R1");
    // directed: R2 post-index address is the old base, R4 register offset
    rf[6] = 32'h1000_0000; rf[7] = 32'h8000_0001;
    step(1, 0, {4'h0, 4'h0, 1'b1, 3'b010, 4'd6, 4'd5, 4'h0, 4'hB, 4'd7}, 1, 0, "R2");
    // directed: R11 reserved bits in register form
    step(1, 0, {4'h0, 4'h0, 1'b1, 3'b010, 4'd6, 4'd5, 4'h3, 4'hB, 4'd7}, 1, 0, "R11");
    // directed: R6 compact base 15 while at hyp level
    step(1, 1, {12'hF82, 4'hF, 4'd5, 4'hE, 8'h10}, 1, 2, "R6");
    // directed: R7 register form Rm 15
    step(1, 0, {4'h1, 4'h0, 1'b1, 3'b010, 4'd6, 4'd5, 4'h0, 4'hB, 4'hF}, 1, 0, "R7");
    // directed: R8 hyp level on a clean word
    step(1, 0, {4'h1, 4'h0, 1'b1, 3'b110, 4'd6, 4'd5, 4'h2, 4'hB, 4'h3}, 1, 2, "R8");
    // directed: R9 condition fails; R5 data/size/user checked on every request
    step(1, 0, {4'h1, 4'h0, 1'b1, 3'b110, 4'd6, 4'd5, 4'h2, 4'hB, 4'h3}, 0, 0, "R9");
    step(1, 1, {12'hF82, 4'd1, 4'd9, 4'hE, 8'h22}, 1, 1, "R5");
    step(0, 1, {12'hF82, 4'd1, 4'd9, 4'hE, 8'h22}, 1, 1, "R10");

    for (int i = 0; i < 3000; i++) begin
      int kind = $urandom_range(0, 3);
      logic [3:0] n, t, m;
      logic [31:0] w;
      logic isa;
      if (i % 64 == 0) for (int k = 0; k < 16; k++) rf[k] = $urandom;
      n = 4'($urandom); t = pick(n); n = pick(t); m = pick(n);
      case (kind)
        0: begin isa = 0; w = {4'($urandom_range(0, 14)), 4'h0, 1'($urandom), 3'b110,
                               n, t, 4'($urandom), 4'hB, 4'($urandom)}; end
        1: begin isa = 0; w = {4'($urandom_range(0, 14)), 4'h0, 1'($urandom), 3'b010,
                               n, t, 4'h0, 4'hB, m}; end
        2: begin isa = 1; w = {12'hF82, n, t, 4'hE, 8'($urandom)}; end
        default: begin isa = 1'($urandom); w = $urandom; end
      endcase
      step($urandom_range(0, 9) != 0, isa, w, $urandom_range(0, 7) != 0,
           ($urandom_range(0, 5) == 0) ? 2'd2 : 2'($urandom_range(0, 1)), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule